// File: doc/BRIEF.md
# SPI Register-Access Slave with Live Status

This block lets a host reach a peripheral's configuration registers over a four-wire serial link. The host pulls the active-low select low and clocks in bytes on the serial input. The block captures each bit on a rising serial-clock edge and moves its output after a falling edge. The first byte of every exchange is a header. It picks read or write, single or burst, and a 6-bit register address. Header addresses at or above a strobe base, sent with the burst flag clear, are commands: they pulse a strobe output and carry no data byte.

The block shifts a status byte out on the serial output during every byte it receives, except a read-data byte. The status byte holds a not-ready flag, the 3-bit operating state and an auxiliary nibble. The host checks the not-ready bit before it starts clocking. On a read data byte the output carries the register contents in place of the status.

The serial pins are brought into the system clock domain through a configurable synchronizer and then edge-detected. The serial clock must therefore stay well below the system clock.

Top module: `spi_stat_slave`

## Requirements
- R1: While a header byte, a write-data byte or a command-strobe byte is shifted in, the serial output carries the status byte MSB first. Bit 7 is the not-ready input, bits 6:4 are the operating state and bits 3:0 are the auxiliary nibble.
- R2: The status bit 7 appears on the serial output within four system clocks of the select falling, before the first rising serial-clock edge.
- R3: Header layout: bit 7 is read (1) or write (0), bit 6 is burst, bits 5:0 are the address. On a write, the eighth rising edge of the data byte produces exactly one `reg_we_o` pulse, with the header address and the received byte.
- R4: On a read, the data byte shifts out the register contents at the current address, MSB first, in place of the status.
- R5: In a burst, the address steps by one after each data byte, wrapping from 63 to 0, until the select rises.
- R6: A header with burst clear and address at or above 0x30 gives a one-cycle `strobe_o` with that address. It writes nothing, and the next byte is a new header. With burst set, the same addresses are ordinary registers.
- R7: After the data byte of a single access, the next byte in the same select window is taken as a new header.
- R8: If the select rises in the middle of a byte, the partial byte is dropped, nothing is written, and the next transaction starts with a header.
- R9: The status byte is captured when each byte starts. A state change during the byte does not alter it, and the following byte shows the new state.
- R10: After reset, `reg_we_o`, `strobe_o` and the serial output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from host |
| spi_cs_n_i | input | 1 | Active-low select |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| xtal_rdy_n_i | input | 1 | Not-ready flag (status bit 7) |
| op_state_i | input | 3 | Operating state code (status bits 6:4) |
| stat_aux_i | input | 4 | Auxiliary status nibble (bits 3:0) |
| reg_addr_o | output | 6 | Register file address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write enable |
| reg_rdata_i | input | 8 | Register read data at `reg_addr_o` |
| strobe_o | output | 1 | One-cycle command strobe |
| strobe_addr_o | output | 6 | Address of the command strobe |

## Verification
Some properties are checked on every cycle. A write and a strobe never coincide, and a strobe lasts one cycle and always lies in the command range. Writes happen only inside a select window. The outgoing shift word changes only on a falling edge or at select start. A burst step raises the address by exactly one, and the bit counter clears once the select rises. Other behaviour needs the bench scenarios: the exact status and read-data values seen bit by bit, a state change in the middle of a byte, wrap-around in a burst, back-to-back headers after a strobe or a single access, and dropped partial bytes.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
   typedef enum logic [0:0] {
      PH_HDR  = 1'b0,
      PH_DATA = 1'b1
   } phase_e;
endpackage

// File: rtl/spi_stat_sync.sv
module spi_stat_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("spi_stat_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= {STAGES{RST_VAL}};
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_stat_shift.sv
module spi_stat_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         cs_start,
   input  logic         sclk_rise,
   input  logic         sclk_fall,
   input  logic         mosi,
   input  logic [W-1:0] load_word,
   output logic         miso,
   output logic         byte_done,
   output logic [W-1:0] rx_byte
);
   localparam int CW = $clog2(W);

   generate
      if (W < 4) begin : g_bad_width
         $error("spi_stat_shift: W must be at least 4");
      end
   endgenerate

   logic [CW-1:0] bitcnt;
   logic [W-2:0]  rx_sh;
   logic [W-1:0]  tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt    <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!active) begin
            bitcnt <= '0;
         end else begin
            if (cs_start) tx_sh <= load_word;
            if (sclk_rise) begin
               rx_sh <= {rx_sh[W-3:0], mosi};
               if (bitcnt == CW'(W-1)) begin
                  rx_byte   <= {rx_sh, mosi};
                  byte_done <= 1'b1;
                  bitcnt    <= '0;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            if (sclk_fall && !cs_start) begin
               if (bitcnt == '0) tx_sh <= load_word;
               else              tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = active & tx_sh[W-1];

   // R9
   tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !cs_start) |=> $stable(tx_sh));

   // R8
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (bitcnt == '0));
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
   import spi_stat_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int STROBE_BASE = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              read_sel,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              strobe,
   output logic [ADDR_W-1:0] strobe_addr
);
   generate
      if (DATA_W != ADDR_W + 2) begin : g_bad_hdr
         $error("spi_stat_ctrl: header must hold two flags plus the address");
      end
      if (STROBE_BASE < 0 || STROBE_BASE >= (1 << ADDR_W)) begin : g_bad_base
         $error("spi_stat_ctrl: STROBE_BASE outside address space");
      end
   endgenerate

   phase_e            phase;
   logic              rw_q, burst_q, adv_q;
   logic [ADDR_W-1:0] addr_q;

   logic              hdr_rw, hdr_burst, hdr_is_strobe;
   logic [ADDR_W-1:0] hdr_addr;

   assign hdr_rw        = rx_byte[DATA_W-1];
   assign hdr_burst     = rx_byte[DATA_W-2];
   assign hdr_addr      = rx_byte[ADDR_W-1:0];
   assign hdr_is_strobe = !hdr_burst && (hdr_addr >= ADDR_W'(STROBE_BASE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_HDR;
         rw_q        <= 1'b0;
         burst_q     <= 1'b0;
         adv_q       <= 1'b0;
         addr_q      <= '0;
         reg_wdata   <= '0;
         reg_we      <= 1'b0;
         strobe      <= 1'b0;
         strobe_addr <= '0;
      end else begin
         reg_we <= 1'b0;
         strobe <= 1'b0;
         adv_q  <= 1'b0;
         if (adv_q) addr_q <= addr_q + 1'b1;
         if (!active) begin
            phase <= PH_HDR;
         end else if (byte_done) begin
            case (phase)
               PH_HDR: begin
                  if (hdr_is_strobe) begin
                     strobe      <= 1'b1;
                     strobe_addr <= hdr_addr;
                  end else begin
                     phase   <= PH_DATA;
                     rw_q    <= hdr_rw;
                     burst_q <= hdr_burst;
                     addr_q  <= hdr_addr;
                  end
               end
               PH_DATA: begin
                  if (!rw_q) begin
                     reg_we    <= 1'b1;
                     reg_wdata <= rx_byte;
                  end
                  if (burst_q) adv_q <= 1'b1;
                  else         phase <= PH_HDR;
               end
               default: phase <= PH_HDR;
            endcase
         end
      end
   end

   assign read_sel = (phase == PH_DATA) && rw_q;
   assign reg_addr = addr_q;

   // R6
   we_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && strobe));

   // R6
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   // R6
   strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (strobe_addr >= ADDR_W'(STROBE_BASE)));

   // R8
   we_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(active));

   // R5
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && active && phase == PH_DATA && burst_q) |=> ##1
         (addr_q == ADDR_W'($past(addr_q, 2) + 1'b1)));
endmodule

// File: rtl/spi_stat_slave.sv
module spi_stat_slave #(
   parameter int ADDR_W        = 6,
   parameter int STATE_W       = 3,
   parameter int STROBE_BASE   = 48,
   parameter int SYNC_STAGES   = 2,
   parameter bit STATUS_AUX_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_sclk_i,
   input  logic                       spi_cs_n_i,
   input  logic                       spi_mosi_i,
   output logic                       spi_miso_o,
   input  logic                       xtal_rdy_n_i,
   input  logic [STATE_W-1:0]         op_state_i,
   input  logic [ADDR_W+1-STATE_W-1:0] stat_aux_i,
   output logic [ADDR_W-1:0]          reg_addr_o,
   output logic [ADDR_W+1:0]          reg_wdata_o,
   output logic                       reg_we_o,
   input  logic [ADDR_W+1:0]          reg_rdata_i,
   output logic                       strobe_o,
   output logic [ADDR_W-1:0]          strobe_addr_o
);
   localparam int DATA_W = ADDR_W + 2;
   localparam int AUX_W  = DATA_W - 1 - STATE_W;

   generate
      if (AUX_W < 1) begin : g_bad_status
         $error("spi_stat_slave: status byte has no room for the auxiliary field");
      end
   endgenerate

   logic s_sclk, s_cs_n, s_mosi;
   logic sclk_q, cs_n_q;
   logic active, cs_start, sclk_rise, sclk_fall;
   logic byte_done, read_sel;
   logic [DATA_W-1:0] rx_byte, status_word, load_word;
   logic [AUX_W-1:0]  aux_bits;

   spi_stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(spi_sclk_i), .q(s_sclk));
   spi_stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(spi_cs_n_i), .q(s_cs_n));
   spi_stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi_i), .q(s_mosi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_n_q <= 1'b1;
      end else begin
         sclk_q <= s_sclk;
         cs_n_q <= s_cs_n;
      end
   end

   assign active    = !s_cs_n;
   assign cs_start  = !s_cs_n && cs_n_q;
   assign sclk_rise = active && s_sclk && !sclk_q;
   assign sclk_fall = active && !s_sclk && sclk_q;

   generate
      if (STATUS_AUX_EN) begin : g_aux_live
         assign aux_bits = stat_aux_i;
      end else begin : g_aux_zero
         assign aux_bits = '0;
      end
   endgenerate

   assign status_word = {xtal_rdy_n_i, op_state_i, aux_bits};
   assign load_word   = read_sel ? reg_rdata_i : status_word;

   spi_stat_shift #(.W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .cs_start  (cs_start),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .mosi      (s_mosi),
      .load_word (load_word),
      .miso      (spi_miso_o),
      .byte_done (byte_done),
      .rx_byte   (rx_byte)
   );

   spi_stat_ctrl #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STROBE_BASE (STROBE_BASE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .byte_done   (byte_done),
      .rx_byte     (rx_byte),
      .read_sel    (read_sel),
      .reg_addr    (reg_addr_o),
      .reg_wdata   (reg_wdata_o),
      .reg_we      (reg_we_o),
      .strobe      (strobe_o),
      .strobe_addr (strobe_addr_o)
   );
endmodule

// File: tb/spi_stat_slave_tb.sv
module spi_stat_slave_tb_top;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic       rdy_n = 1'b0;
   logic [2:0] st = 3'd1;
   logic [3:0] aux = 4'h5;
   logic [5:0] raddr, saddr;
   logic [7:0] wdata, rdata;
   logic       we, stb;

   logic [7:0] mem [64];
   logic [7:0] expv [64];
   int n_chk = 0, n_fail = 0, we_cnt = 0, stb_cnt = 0;
   logic [5:0] last_stb = '0;
   bit done = 0;

   always #4 clk = ~clk;

   spi_stat_slave dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n),
      .spi_mosi_i(mosi), .spi_miso_o(miso), .xtal_rdy_n_i(rdy_n),
      .op_state_i(st), .stat_aux_i(aux), .reg_addr_o(raddr),
      .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata),
      .strobe_o(stb), .strobe_addr_o(saddr));

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 37 + 11) & 8'hFF);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      end else begin
         if (we) begin mem[raddr] <= wdata; we_cnt <= we_cnt + 1; end
         if (stb) begin stb_cnt <= stb_cnt + 1; last_stb <= saddr; end
      end
   end
   assign rdata = mem[raddr];

   function automatic logic [7:0] stat_now();
      return {rdy_n, st, aux};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
      end
   endtask

   task automatic cs_low();
      @(negedge clk); cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (4) @(negedge clk); cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                       input int nbits = 8, input int chg_bit = -1,
                       input logic [2:0] chg_state = 3'd0);
      rx = '0;
      for (int b = 7; b > 7 - nbits; b--) begin
         @(negedge clk); mosi = tx[b];
         repeat (HALF - 1) @(negedge clk);
         rx[b] = miso;
         if (b == chg_bit) st = chg_state;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
   endtask

   task automatic single_write(input logic [5:0] a, input logic [7:0] d);
      logic [7:0] r; logic [7:0] s; int w0;
      w0 = we_cnt;
      cs_low();
      s = stat_now(); xfer({2'b00, a}, r);
      check(r == s, "R1 status on header", r, s);
      s = stat_now(); xfer(d, r);
      check(r == s, "R1 status on write data", r, s);
      cs_high();
      check(we_cnt == w0 + 1, "R3 one write pulse", we_cnt - w0, 1);
      check(mem[a] == d, "R3 write lands at address", mem[a], d);
      expv[a] = d;
   endtask

   task automatic single_read(input logic [5:0] a);
      logic [7:0] r; logic [7:0] s;
      cs_low();
      s = stat_now(); xfer({2'b10, a}, r);
      check(r == s, "R1 status on read header", r, s);
      xfer(8'h00, r);
      check(r == expv[a], "R4 read data", r, expv[a]);
      cs_high();
   endtask

   task automatic burst_write(input logic [5:0] a, input int n);
      logic [7:0] r; logic [7:0] s; logic [7:0] d;
      cs_low();
      s = stat_now(); xfer({2'b01, a}, r);
      check(r == s, "R1 status on burst header", r, s);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         expv[6'(a + k)] = d;
         s = stat_now(); xfer(d, r);
         check(r == s, "R1 status on burst data", r, s);
      end
      cs_high();
   endtask

   task automatic burst_read(input logic [5:0] a, input int n);
      logic [7:0] r;
      cs_low();
      xfer({2'b11, a}, r);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, r);
         check(r == expv[6'(a + k)], "R5 burst read step", r, expv[6'(a + k)]);
      end
      cs_high();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r; logic [7:0] s; int w0, s0;
      void'($urandom(32'd4242));
      for (int i = 0; i < 64; i++) expv[i] = init_val(i);
      repeat (5) @(negedge clk);
      // R10 reset state
      check(we == 0 && stb == 0 && miso == 0, "R10 reset outputs", {we, stb, miso}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(we == 0 && stb == 0 && miso == 0, "R10 idle after reset", {we, stb, miso}, 0);

      // R2 ready bit visible before first rising edge, both polarities
      rdy_n = 1'b1; cs_low();
      check(miso == 1'b1, "R2 not-ready bit high", miso, 1);
      cs_high();
      rdy_n = 1'b0; cs_low();
      check(miso == 1'b0, "R2 ready bit low", miso, 0);
      cs_high();

      single_write(6'd5, 8'hA7);
      single_read(6'd5);
      st = 3'd6; aux = 4'hC; rdy_n = 1'b1;
      single_write(6'd47, 8'h3C);
      single_read(6'd47);
      rdy_n = 1'b0;

      // R5 burst with wrap 62,63,0,1
      burst_write(6'd62, 4);
      burst_read(6'd62, 4);
      check(mem[0] == expv[0], "R5 wrap write to 0", mem[0], expv[0]);

      // R6 strobe: no write, next byte is a header
      w0 = we_cnt; s0 = stb_cnt;
      cs_low();
      s = stat_now(); xfer({2'b00, 6'h33}, r);
      check(r == s, "R1 status on strobe", r, s);
      check(stb_cnt == s0 + 1 && last_stb == 6'h33, "R6 strobe pulse", last_stb, 6'h33);
      xfer({2'b00, 6'd9}, r); xfer(8'h5E, r);
      cs_high();
      check(we_cnt == w0 + 1, "R6 strobe then header write", we_cnt - w0, 1);
      expv[9] = 8'h5E;
      single_read(6'd9);
      // R6 burst flag set: 0x30 is a plain register
      s0 = stb_cnt;
      burst_write(6'h30, 2);
      burst_read(6'h30, 2);
      check(stb_cnt == s0, "R6 no strobe with burst set", stb_cnt - s0, 0);

      // R7 single write then read header in one window
      cs_low();
      xfer({2'b00, 6'd12}, r); xfer(8'h81, r);
      xfer({2'b10, 6'd12}, r); xfer(8'h00, r);
      cs_high();
      check(r == 8'h81, "R7 next byte is header", r, 8'h81);
      expv[12] = 8'h81;

      // R8 abort mid data byte and mid header
      w0 = we_cnt;
      cs_low();
      xfer({2'b00, 6'd20}, r); xfer(8'hFF, r, 4);
      cs_high();
      check(we_cnt == w0, "R8 no write after abort", we_cnt - w0, 0);
      cs_low(); xfer({2'b00, 6'd20}, r, 3); cs_high();
      single_read(6'd20);

      // R9 status latched at byte start
      st = 3'd2;
      cs_low();
      s = stat_now(); xfer({2'b00, 6'd3}, r, 8, 5, 3'd7);
      check(r == s, "R9 status stable mid byte", r, s);
      s = stat_now(); xfer(8'h44, r);
      check(r == s && r[6:4] == 3'd7, "R9 new state next byte", r, s);
      cs_high();
      expv[3] = 8'h44;

      // random mix
      for (int it = 0; it < 30; it++) begin
         logic [5:0] a;
         a = 6'($urandom % 48);
         st = 3'($urandom); aux = 4'($urandom); rdy_n = 1'($urandom);
         case ($urandom % 4)
            0: single_write(a, 8'($urandom));
            1: single_read(a);
            2: burst_write(6'($urandom), 1 + int'($urandom % 3));
            default: burst_read(6'($urandom), 1 + int'($urandom % 3));
         endcase
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule